// File: doc/BRIEF.md
# Peak-Current PWM Cycle Engine

This block is the timing core of a digitally modelled peak-current-mode converter. A period counter stands in for the oscillator. Each switching cycle opens by driving the main switch pulse high. The pulse then ends at the earliest of four events:

- the peak-current compare trips;
- the hard over-current input trips;
- the on-time reaches the maximum-duty count;
- the on-time reaches the volt-second count.

Both current comparators are masked for a programmable blanking window at the start of every cycle. Slope compensation is modelled as a digital ramp. The ramp grows by a programmable step on every clock of the cycle and is added to the sensed current before the comparison.

A clock of 100 MHz covers the usual switching range with small counts. In that case, 25 kHz to 800 kHz maps to periods of 4000 down to 125 clocks, and a 100 ns blanking window is 10 clocks. The duty caps are counts, so a 95 % cap at a 200-clock period is a maximum-duty count of 190. All settings are taken at the start of a cycle and hold for that whole cycle. An over-current event cuts only the present pulse, and the next cycle starts as normal.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: While `en` is low, `gate_o` is low from the next clock edge and the cycle counter is held at zero. The first clock edge that sees `en` high (or `rst_n` released with `en` high) starts a new cycle with count 0.
- R2: A cycle lasts `max(period_cfg, 2)` clocks. The count runs 0 up to that value minus 1 and then restarts at 0.
- R3: With no trips, `gate_o` is high for exactly `min(maxon_cfg, vsec_cfg, cycle length)` clocks. It goes high on the clock edge that starts the cycle.
- R4: If `min(maxon_cfg, vsec_cfg)` is 0, no pulse is produced in that cycle (0 % duty).
- R5: While the cycle count is below `blank_cfg`, neither `ilim_trip` nor the peak-current compare affects `gate_o`.
- R6: When unblanked at count k, the peak-current compare trips if `isense + k*slope_cfg >= ctrl_level`. `gate_o` is then low from the next edge, giving a pulse of k+1 clocks.
- R7: `ilim_trip` high at an unblanked count k below the last count of the cycle, while `gate_o` is high, ends the pulse on the next edge. `ilim_hit_o` is high for that one clock, on the same edge as the fall of `gate_o`. It is never high otherwise.
- R8: After any trip, the next cycle starts with `gate_o` high again and its full limits.
- R9: The period, blanking, maximum-duty, volt-second and slope settings are sampled only at the edge that starts a cycle. Changes made during a cycle take effect at the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the pulse off and the counter at zero |
| period_cfg | input | CW | Cycle length in clocks (values below 2 act as 2) |
| blank_cfg | input | CW | Leading-edge blanking length in clocks |
| maxon_cfg | input | CW | Maximum-duty on-time in clocks |
| vsec_cfg | input | CW | Volt-second on-time limit in clocks |
| slope_cfg | input | SW | Ramp increment per clock |
| isense | input | DW | Digitized sensed switch current |
| ctrl_level | input | DW | Peak-current setpoint from the control loop |
| ilim_trip | input | 1 | Hard current-limit comparator output |
| gate_o | output | 1 | Main switch pulse |
| ilim_hit_o | output | 1 | One-clock flag: hard limit ended the pulse |

## Verification
The edge that starts a cycle raises `gate_o` immediately. A trip seen while the count is k lowers `gate_o` one edge later, and `ilim_hit_o` rises on that same edge. A cap of L clocks keeps the pulse high for exactly L edges. The bench changes inputs and samples outputs only on falling edges. It indexes every sample by its count since the start edge, so the sample at index j shows the state after the edge where the count became j. For each configuration it compares the full pulse shape of one cycle, and the position of the hit flag, against a width computed arithmetically from the four terminators.

// File: rtl/pwm_cycle_ctrl.sv
module pwm_cycle_ctrl #(
  parameter int CW = 12,
  parameter int DW = 10,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period_cfg,
  input  logic [CW-1:0] blank_cfg,
  input  logic [CW-1:0] maxon_cfg,
  input  logic [CW-1:0] vsec_cfg,
  input  logic [SW-1:0] slope_cfg,
  input  logic [DW-1:0] isense,
  input  logic [DW-1:0] ctrl_level,
  input  logic          ilim_trip,
  output logic          gate_o,
  output logic          ilim_hit_o
);
  localparam int RW = CW + SW;
  localparam logic [CW-1:0] MINPER = CW'(2);

  logic [CW-1:0] cnt, per_q, blank_q, lim_q;
  logic [SW-1:0] slope_q;
  logic [RW-1:0] ramp;
  logic          run, gate, hit;

  wire [CW-1:0] per_eff   = (period_cfg < MINPER) ? MINPER : period_cfg;
  wire [CW-1:0] lim_new   = (maxon_cfg < vsec_cfg) ? maxon_cfg : vsec_cfg;
  wire          cyc_end   = !run || (cnt == per_q - CW'(1));
  wire          armed     = gate && (cnt >= blank_q);
  wire [RW:0]   sense_sum = (RW+1)'(isense) + (RW+1)'(ramp);
  wire          pwm_trip  = armed && (sense_sum >= (RW+1)'(ctrl_level));
  wire          lim_trip  = armed && ilim_trip;
  wire          at_cap    = (cnt + CW'(1)) >= lim_q;

  assign gate_o     = gate;
  assign ilim_hit_o = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; per_q <= MINPER; blank_q <= '0; lim_q <= '0;
      slope_q <= '0; ramp <= '0; run <= 1'b0; gate <= 1'b0; hit <= 1'b0;
    end else if (!en) begin
      cnt <= '0; ramp <= '0; run <= 1'b0; gate <= 1'b0; hit <= 1'b0;
    end else begin
      hit <= lim_trip && !cyc_end;
      if (cyc_end) begin
        cnt     <= '0;
        run     <= 1'b1;
        per_q   <= per_eff;
        blank_q <= blank_cfg;
        lim_q   <= lim_new;
        slope_q <= slope_cfg;
        ramp    <= '0;
        gate    <= (lim_new != '0);
      end else begin
        cnt  <= cnt + CW'(1);
        ramp <= ramp + RW'(slope_q);
        gate <= gate && !at_cap && !pwm_trip && !lim_trip;
      end
    end
  end

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate_o); // R1
  AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < per_q); // R2
  AST_CAP_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !cyc_end && at_cap) |=> !gate_o); // R3
  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate && !cyc_end && cnt < blank_q && !at_cap) |=> (!en || gate_o)); // R5
  AST_HIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_hit_o |-> (!gate_o && $past(gate_o))); // R7
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_hit_o |=> !ilim_hit_o); // R7
endmodule

// File: tb/pwm_cycle_ctrl_bench.sv
module pwm_cycle_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, en = 1'b0, ilim = 1'b0;
  logic [11:0] per_c = 12'd4, blk_c = '0, mx_c = '0, vs_c = '0;
  logic [5:0]  slp_c = '0;
  logic [9:0]  isn_c = '0, ctl_c = '0;
  wire         gate, hit;
  int checks = 0, fails = 0;

  pwm_cycle_ctrl u_pwm_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .period_cfg(per_c), .blank_cfg(blk_c),
    .maxon_cfg(mx_c), .vsec_cfg(vs_c), .slope_cfg(slp_c), .isense(isn_c),
    .ctrl_level(ctl_c), .ilim_trip(ilim), .gate_o(gate), .ilim_hit_o(hit));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic run_one(input int per, input int blank, input int mx, input int vs,
                         input int slope, input int isn, input int ctl, input int ilat);
    int w, hexp, hpos, gmask, emask;
    per_c = 12'(per); blk_c = 12'(blank); mx_c = 12'(mx); vs_c = 12'(vs);
    slp_c = 6'(slope); isn_c = 10'(isn); ctl_c = 10'(ctl);
    @(negedge clk); en = 1'b1;
    gmask = 0; hpos = 0;
    for (int j = 0; j <= per; j++) begin
      @(negedge clk);
      if (j < per && gate) gmask |= (1 << j);
      if (j >= 1 && hit) hpos = (hpos == 0) ? j : 99;
      ilim = (j < per) && (j == ilat);
    end
    en = 1'b0; ilim = 1'b0;
    w = (mx < vs) ? mx : vs;
    if (w > per) w = per;
    for (int k = blank; k < w; k++)
      if (k == ilat || isn + k * slope >= ctl) begin w = k + 1; break; end
    emask = (1 << w) - 1;
    hexp = (ilat >= blank && ilat < w && ilat != per - 1) ? ilat + 1 : 0;
    chk(gmask == emask, "R2 R3 R4 R5 R6 pulse shape", gmask, emask);
    chk(hpos == hexp, "R7 hit position", hpos, hexp);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int pers[3]  = '{4, 7, 12};
    int blks[2]  = '{0, 2};
    int mxs[4]   = '{0, 1, 3, 20};
    int vss[2]   = '{2, 50};
    int ilats[4] = '{99, 0, 1, 3};
    int exp_g;

    en = 1'b1; per_c = 12'd4; mx_c = 12'd3; vs_c = 12'd50;
    repeat (3) @(negedge clk);
    chk(gate == 1'b0, "R1 reset gate", gate, 0);
    chk(hit == 1'b0, "R1 reset hit", hit, 0);
    en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    foreach (pers[a]) foreach (blks[b]) foreach (mxs[c]) foreach (vss[d])
      foreach (ilats[e]) begin
        run_one(pers[a], blks[b], mxs[c], vss[d], 0, 0, 100, ilats[e]);
        run_one(pers[a], blks[b], mxs[c], vss[d], 2, 10, 15, ilats[e]);
      end

    // R9 R8: settings changed mid-cycle apply next cycle; restart after hard trip
    per_c = 12'd8; blk_c = '0; mx_c = 12'd6; vs_c = 12'd50; slp_c = '0;
    isn_c = '0; ctl_c = 10'd100;
    @(negedge clk); en = 1'b1;
    for (int j = 0; j < 14; j++) begin
      @(negedge clk);
      exp_g = (j <= 3 || j == 8 || j == 9 || j == 13) ? 1 : 0;
      chk(gate == exp_g[0], "R8 R9 gate after mid-cycle change", gate, exp_g);
      chk(hit == (j == 4), "R7 hit in latch run", hit, (j == 4) ? 1 : 0);
      if (j == 2) begin per_c = 12'd5; mx_c = 12'd2; end
      ilim = (j == 3);
    end
    en = 1'b0; ilim = 1'b0;
    @(negedge clk);

    // R2: period below two acts as two
    per_c = 12'd1; mx_c = 12'd1; vs_c = 12'd50;
    @(negedge clk); en = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk(gate == ((j % 2) == 0), "R2 minimum period", gate, ((j % 2) == 0) ? 1 : 0);
    end
    en = 1'b0;
    @(negedge clk);

    // R1: dropping enable mid-pulse, then restart at count 0
    per_c = 12'd8; mx_c = 12'd6; vs_c = 12'd50;
    @(negedge clk); en = 1'b1;
    @(negedge clk); @(negedge clk); en = 1'b0; ilim = 1'b1;
    for (int j = 0; j < 9; j++) begin
      @(negedge clk);
      chk(gate == 1'b0, "R1 held off while disabled", gate, 0);
      chk(hit == 1'b0, "R1 no hit while disabled", hit, 0);
    end
    ilim = 1'b0; en = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk(gate == (j < 6), "R1 restart from count zero", gate, (j < 6) ? 1 : 0);
    end
    en = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule